// File: doc/BRIEF.md
# Core Message Mailbox

This block carries 32-bit messages between one local compute core and any number of remote agents. It has three queues. One inbound queue is filled by remote agents through a small memory-mapped register port and emptied by the local core through a channel port. Two outbound queues are filled by the core through the channel port and emptied by remote agents through memory-mapped reads. One of the two outbound queues drives an interrupt line while it holds a message.

The channel side blocks. A read request held against an empty inbound queue gets no acknowledge until a message lands, and a write request held against a full outbound queue gets no acknowledge until a remote read drains it. The memory-mapped side never blocks. A write to a full inbound queue is thrown away and sets a sticky overflow flag. A read of an empty outbound queue returns zero. Occupancy counts for all three queues are visible to the core as ports and to remote agents through a status register.

Top module: `mailbox_unit`

## Requirements
- R1: After reset all three counts are zero, the interrupt is low, the overflow flag is clear, both channel acknowledges are low and a status read returns 0.
- R2: The inbound queue returns messages to the channel reader in the order the memory-mapped writes delivered them.
- R3: The inbound queue holds 4 messages. A memory-mapped write to address 0 while it holds 4 is dropped, leaves the stored messages intact and sets the overflow flag.
- R4: The overflow flag stays set until a memory-mapped write to address 3, which clears it.
- R5: `ch_rd_ack` is low while the inbound queue is empty and the request waits. It goes high, with the message on `ch_rd_data`, in the cycle after a memory-mapped write stores a message.
- R6: A channel write with `ch_wr_sel`=0 goes to the plain outbound queue, which holds 1 message. While it is full `ch_wr_ack` stays low. A memory-mapped read of address 1 returns the message on `mm_rdata` one cycle later and frees the entry.
- R7: A channel write with `ch_wr_sel`=1 goes to the interrupt outbound queue, which holds 1 message and is read at address 2 in the same way.
- R8: `irq` rises in the cycle after a write is accepted into the interrupt queue and falls in the cycle after the read that empties it. Writes to the plain queue never raise it.
- R9: A memory-mapped read of an empty outbound queue returns 0 and leaves every count unchanged.
- R10: A read of address 3 returns the inbound count in bits 7:0, the plain outbound count in bits 15:8, the interrupt outbound count in bits 23:16 and the overflow flag in bit 24, with zeros elsewhere.
- R11: Memory-mapped writes to addresses 1 and 2 have no effect, and a read of address 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_rd_req | input | 1 | Core requests the next inbound message |
| ch_rd_ack | output | 1 | Inbound message taken at this edge |
| ch_rd_data | output | 32 | Head of the inbound queue |
| ch_wr_req | input | 1 | Core requests an outbound write |
| ch_wr_sel | input | 1 | 0 = plain outbound queue, 1 = interrupt outbound queue |
| ch_wr_data | input | 32 | Outbound message |
| ch_wr_ack | output | 1 | Outbound message accepted at this edge |
| ch_in_count | output | 3 | Inbound occupancy |
| ch_out_count | output | 1 | Plain outbound occupancy |
| ch_irq_count | output | 1 | Interrupt outbound occupancy |
| mm_wr_en | input | 1 | Memory-mapped write strobe |
| mm_rd_en | input | 1 | Memory-mapped read strobe |
| mm_addr | input | 2 | Register select |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | High while the interrupt outbound queue holds a message |

## Verification
The bench fills the inbound queue to capacity and pushes one more message. A design that accepted it would corrupt the order or report 5 entries. A design that forgot the drop would leave the overflow bit clear. The bench holds channel requests against empty and full queues. A design without stalls would acknowledge early, hand over stale data or lose a write. The bench tracks the exact cycle `irq` rises and falls, and checks that plain-queue writes leave it low. It also reads empty queues and writes to read-only addresses, where a faulty decode would pop garbage or disturb counts.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MSG_W   = 32;
  localparam int FIELD_W = 8;
  localparam int OVF_BIT = 24;

  typedef enum logic [1:0] {
    REG_INBOX  = 2'd0,
    REG_OUTBOX = 2'd1,
    REG_IRQBOX = 2'd2,
    REG_STATUS = 2'd3
  } mbx_reg_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R2
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R3
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    push && !pop |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/mbx_mmio.sv
module mbx_mmio
  import mbx_pkg::*;
#(
  parameter int IN_CW  = 3,
  parameter int OUT_CW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mm_wr_en,
  input  logic              mm_rd_en,
  input  logic [1:0]        mm_addr,
  input  logic [MSG_W-1:0]  mm_wdata,
  output logic [MSG_W-1:0]  mm_rdata,
  input  logic              in_full,
  input  logic [IN_CW-1:0]  in_count,
  input  logic [OUT_CW-1:0] out_count,
  input  logic [OUT_CW-1:0] irq_count,
  input  logic              out_empty,
  input  logic              irq_empty,
  input  logic [MSG_W-1:0]  out_head,
  input  logic [MSG_W-1:0]  irq_head,
  output logic              in_push,
  output logic [MSG_W-1:0]  in_data,
  output logic              out_pop,
  output logic              irq_pop,
  output logic              overflow
);
  logic in_sel, clr_sel;
  logic [MSG_W-1:0] status;

  assign in_sel  = mm_wr_en && (mm_addr == REG_INBOX);
  assign clr_sel = mm_wr_en && (mm_addr == REG_STATUS);
  assign in_push = in_sel && !in_full;
  assign in_data = mm_wdata;
  assign out_pop = mm_rd_en && (mm_addr == REG_OUTBOX) && !out_empty;
  assign irq_pop = mm_rd_en && (mm_addr == REG_IRQBOX) && !irq_empty;

  always_comb begin
    status = '0;
    status[FIELD_W-1:0]           = FIELD_W'(in_count);
    status[2*FIELD_W-1:FIELD_W]   = FIELD_W'(out_count);
    status[3*FIELD_W-1:2*FIELD_W] = FIELD_W'(irq_count);
    status[OVF_BIT]               = overflow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
      mm_rdata <= '0;
    end else begin
      if (in_sel && in_full) overflow <= 1'b1;
      else if (clr_sel)      overflow <= 1'b0;
      if (mm_rd_en) begin
        case (mm_addr)
          REG_OUTBOX: mm_rdata <= out_empty ? '0 : out_head;
          REG_IRQBOX: mm_rdata <= irq_empty ? '0 : irq_head;
          REG_STATUS: mm_rdata <= status;
          default:    mm_rdata <= '0;
        endcase
      end
    end
  end

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow && !clr_sel |=> overflow);
  // R3
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(in_sel && in_full));
endmodule

// File: rtl/mailbox_unit.sv
module mailbox_unit
  import mbx_pkg::*;
#(
  parameter int IN_DEPTH  = 4,
  parameter int OUT_DEPTH = 1,
  localparam int IN_CW    = $clog2(IN_DEPTH + 1),
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_rd_req,
  output logic              ch_rd_ack,
  output logic [31:0]       ch_rd_data,
  input  logic              ch_wr_req,
  input  logic              ch_wr_sel,
  input  logic [31:0]       ch_wr_data,
  output logic              ch_wr_ack,
  output logic [IN_CW-1:0]  ch_in_count,
  output logic [OUT_CW-1:0] ch_out_count,
  output logic [OUT_CW-1:0] ch_irq_count,
  input  logic              mm_wr_en,
  input  logic              mm_rd_en,
  input  logic [1:0]        mm_addr,
  input  logic [31:0]       mm_wdata,
  output logic [31:0]       mm_rdata,
  output logic              irq
);
  logic             in_push, in_full, in_empty, in_pop;
  logic [MSG_W-1:0] in_data;
  logic             out_push, out_pop, out_full, out_empty;
  logic             irq_push, irq_pop, irq_full, irq_empty;
  logic [MSG_W-1:0] out_head, irq_head;
  logic             overflow;

  assign in_pop    = ch_rd_req && !in_empty;
  assign ch_rd_ack = in_pop;
  assign out_push  = ch_wr_req && !ch_wr_sel && !out_full;
  assign irq_push  = ch_wr_req &&  ch_wr_sel && !irq_full;
  assign ch_wr_ack = out_push || irq_push;
  assign irq       = !irq_empty;

  mbx_fifo #(.W(MSG_W), .DEPTH(IN_DEPTH)) u_inbox (
    .clk(clk), .rst(rst), .push(in_push), .pop(in_pop), .wdata(in_data),
    .head(ch_rd_data), .count(ch_in_count), .full(in_full), .empty(in_empty));

  mbx_fifo #(.W(MSG_W), .DEPTH(OUT_DEPTH)) u_outbox (
    .clk(clk), .rst(rst), .push(out_push), .pop(out_pop), .wdata(ch_wr_data),
    .head(out_head), .count(ch_out_count), .full(out_full), .empty(out_empty));

  mbx_fifo #(.W(MSG_W), .DEPTH(OUT_DEPTH)) u_irqbox (
    .clk(clk), .rst(rst), .push(irq_push), .pop(irq_pop), .wdata(ch_wr_data),
    .head(irq_head), .count(ch_irq_count), .full(irq_full), .empty(irq_empty));

  mbx_mmio #(.IN_CW(IN_CW), .OUT_CW(OUT_CW)) u_mmio (
    .clk(clk), .rst(rst), .mm_wr_en(mm_wr_en), .mm_rd_en(mm_rd_en),
    .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .in_full(in_full), .in_count(ch_in_count), .out_count(ch_out_count),
    .irq_count(ch_irq_count), .out_empty(out_empty), .irq_empty(irq_empty),
    .out_head(out_head), .irq_head(irq_head), .in_push(in_push),
    .in_data(in_data), .out_pop(out_pop), .irq_pop(irq_pop),
    .overflow(overflow));

  // R5
  rd_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ch_rd_ack |-> ch_in_count != '0);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ch_wr_ack && ch_wr_sel));
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(mm_rd_en && mm_addr == REG_IRQBOX));
endmodule

// File: tb/mailbox_unit_test.sv
module mailbox_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ch_rd_req = 0, ch_wr_req = 0, ch_wr_sel = 0;
  logic [31:0] ch_wr_data = '0;
  logic mm_wr_en = 0, mm_rd_en = 0;
  logic [1:0] mm_addr = '0;
  logic [31:0] mm_wdata = '0;
  logic ch_rd_ack, ch_wr_ack, irq;
  logic [31:0] ch_rd_data, mm_rdata;
  logic [2:0] ch_in_count;
  logic ch_out_count, ch_irq_count;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mailbox_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mm_write(input logic [1:0] a, input logic [31:0] d);
    mm_wr_en = 1; mm_addr = a; mm_wdata = d;
    @(posedge clk); @(negedge clk);
    mm_wr_en = 0;
  endtask

  task automatic mm_read(input logic [1:0] a, output logic [31:0] d);
    mm_rd_en = 1; mm_addr = a;
    @(posedge clk); @(negedge clk);
    mm_rd_en = 0; d = mm_rdata;
  endtask

  task automatic ch_read(input string req, input logic [31:0] exp);
    ch_rd_req = 1; #1;
    chk(req, {31'd0, ch_rd_ack}, 32'd1);
    chk(req, ch_rd_data, exp);
    @(posedge clk); @(negedge clk);
    ch_rd_req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] s;
    chk("R1 counts", {29'd0, ch_in_count}, 0);
    chk("R1 out", {31'd0, ch_out_count}, 0);
    chk("R1 irqcnt", {31'd0, ch_irq_count}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 acks", {30'd0, ch_rd_ack, ch_wr_ack}, 0);
    mm_read(2'd3, s);
    chk("R1 R10 status", s, 32'h0);
  endtask

  task automatic t_order;
    logic [31:0] s;
    for (int i = 0; i < 4; i++) mm_write(2'd0, 32'hA000 + i);
    mm_read(2'd3, s);
    chk("R10 status four", s, 32'h0000_0004);
    for (int i = 0; i < 4; i++) ch_read("R2 order", 32'hA000 + i);
    chk("R2 empty", {29'd0, ch_in_count}, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] s;
    for (int i = 0; i < 4; i++) mm_write(2'd0, 32'hB000 + i);
    mm_write(2'd0, 32'hDEAD);
    chk("R3 count", {29'd0, ch_in_count}, 4);
    mm_read(2'd3, s);
    chk("R3 R10 ovf", s, 32'h0100_0004);
    for (int i = 0; i < 4; i++) ch_read("R3 intact", 32'hB000 + i);
    mm_read(2'd3, s);
    chk("R4 sticky", s, 32'h0100_0000);
    mm_write(2'd3, 32'h0);
    mm_read(2'd3, s);
    chk("R4 cleared", s, 32'h0);
  endtask

  task automatic t_stall;
    ch_rd_req = 1;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R5 stall", {31'd0, ch_rd_ack}, 0);
      @(negedge clk);
    end
    mm_write(2'd0, 32'hC0DE);
    #1;
    chk("R5 ack", {31'd0, ch_rd_ack}, 1);
    chk("R5 data", ch_rd_data, 32'hC0DE);
    @(posedge clk); @(negedge clk);
    ch_rd_req = 0;
    chk("R5 drained", {29'd0, ch_in_count}, 0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    ch_wr_req = 1; ch_wr_sel = 0; ch_wr_data = 32'h1111; #1;
    chk("R6 ack", {31'd0, ch_wr_ack}, 1);
    @(posedge clk); @(negedge clk);
    ch_wr_data = 32'h2222; #1;
    chk("R6 count", {31'd0, ch_out_count}, 1);
    chk("R8 plain no irq", {31'd0, irq}, 0);
    chk("R6 stall", {31'd0, ch_wr_ack}, 0);
    @(negedge clk); #1;
    chk("R6 still stalled", {31'd0, ch_wr_ack}, 0);
    mm_read(2'd1, d);
    chk("R6 data", d, 32'h1111);
    #1; chk("R6 resume", {31'd0, ch_wr_ack}, 1);
    @(posedge clk); @(negedge clk);
    ch_wr_req = 0;
    mm_read(2'd1, d);
    chk("R6 second", d, 32'h2222);
    chk("R6 empty", {31'd0, ch_out_count}, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    ch_wr_req = 1; ch_wr_sel = 1; ch_wr_data = 32'h3333; #1;
    chk("R7 ack", {31'd0, ch_wr_ack}, 1);
    chk("R8 irq before", {31'd0, irq}, 0);
    @(posedge clk); @(negedge clk);
    ch_wr_req = 0; ch_wr_sel = 0;
    chk("R8 irq up", {31'd0, irq}, 1);
    chk("R7 count", {31'd0, ch_irq_count}, 1);
    chk("R7 plain untouched", {31'd0, ch_out_count}, 0);
    mm_read(2'd2, d);
    chk("R7 data", d, 32'h3333);
    chk("R8 irq down", {31'd0, irq}, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    mm_read(2'd1, d);
    chk("R9 empty plain", d, 0);
    mm_read(2'd2, d);
    chk("R9 empty irq", d, 0);
    mm_write(2'd1, 32'h5555);
    mm_write(2'd2, 32'h6666);
    mm_read(2'd3, d);
    chk("R9 R11 status", d, 32'h0);
    chk("R11 irq", {31'd0, irq}, 0);
    mm_write(2'd0, 32'h7777);
    mm_read(2'd0, d);
    chk("R11 addr0 read", d, 0);
    ch_read("R11 inbox kept", 32'h7777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_order();
    t_overflow();
    t_stall();
    t_plain();
    t_irq();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule